// File: doc/BRIEF.md
# Soft-Mute Gain Ramp for a Stereo Sample Stream

This block fades a stereo audio stream to silence and back without an audible click. It holds one gain level that both channels share. The level moves one count at a time, either down toward zero (silence) while mute is requested, or toward the programmed attenuation level while mute is off. A step happens once every fixed number of audio frames. That number comes from the speed-mode input, so the fade lasts about the same absolute time at every sample rate. A full fade therefore takes a number of frames proportional to the programmed level.

The block runs from a fast system clock. It detects rising edges of the left/right word clock and does all of its work at those edges: it scales each incoming sample by the current gain, registers the result and advances the ramp. If the mute request changes in the middle of a fade, the level turns round from wherever it is and keeps the same step rate. A change of the target level while unmuted is also reached step by step, never by a jump. A flag reports when the output is fully silenced by a mute.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `pwr_dn_n` is low at a clock edge, the gain level is loaded with `att_level`, the outputs are 0 and `muted` is 0. After release, nothing changes until the first rising edge of `word_clk`. A `word_clk` that is already high at release does not count as an edge.
- R2: While `mute_req` is 1, the gain level falls by exactly one count per step until it reaches 0, then stays at 0.
- R3: While `mute_req` is 0, the gain level moves by one count per step toward `att_level` and stops there.
- R4: One step takes 4 frames when `speed_sel` is 2'b00, 8 frames when it is 2'b01, and 16 frames when it is 2'b10 or 2'b11. The frame counter runs only while the level differs from its goal and is cleared whenever the two are equal.
- R5: If the mute request flips before the ramp ends, the level reverses from its current value. The frame counter is not restarted, so the step rate stays the same.
- R6: Starting from rest, a complete fade in either direction takes exactly `att_level` × (frames per step) frames.
- R7: At each `word_clk` rising edge, each output register takes trunc0(in × g / 256). Here g is the gain level before that edge's step, the input and output are 24-bit two's complement, and trunc0 rounds toward zero. Gain 0 gives silence and gain 255 is the largest gain.
- R8: `muted` is 1 exactly when the gain level is 0 and `mute_req` is 1. A level of 0 reached without a mute request leaves `muted` at 0.
- R9: A change of `att_level` while unmuted is followed one count per step. The level never jumps.
- R10: `out_l` and `out_r` change only at clock edges where a `word_clk` rising edge has been detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the word clock |
| pwr_dn_n | input | 1 | Synchronous active-low power-down and reset |
| word_clk | input | 1 | Left/right word clock, one period per stereo frame |
| mute_req | input | 1 | 1 requests a fade to silence |
| att_level | input | 8 | Target gain level when unmuted (0 silent, 255 maximum) |
| speed_sel | input | 2 | Rate mode: 00 normal, 01 double, 10/11 quad |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_l | output | 24 | Left scaled sample, signed, registered |
| out_r | output | 24 | Right scaled sample, signed, registered |
| muted | output | 1 | Gain is 0 while a mute is requested |

## Verification
The hardest case to reach is a reversal that lands part way through a step interval, where a wrong restart of the frame counter only shifts later steps by a few frames. The bench releases and re-asserts the mute after frame counts that are not multiples of the step length. It tracks the level through an arithmetic model of the counter and compares every frame's scaled output against that model. A full sweep of all 256 gain levels against extreme and rounding-sensitive inputs covers the truncation toward zero.

// File: rtl/smute_pkg.sv
// Shared definitions for the soft-mute gain ramp.
// Assumes: gain is an unsigned level in which 0 means silence.
package smute_pkg;
    localparam int GAIN_W = 8;

    // Rate mode encoding on the speed input
    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_X = 2'b11
    } speed_e;
endpackage

// File: rtl/smute_edge_detect.sv
// Detects rising edges of the word clock in the system clock domain.
// Assumes: word_clk is already synchronous to clk. The history flop resets
// high, so a word clock that is high at release is not taken as an edge.
module smute_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic word_clk,
    output logic tick
);
    logic prev_q;

    // Remember the word clock level from the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= word_clk;
    end

    assign tick = word_clk & ~prev_q;
endmodule

// File: rtl/smute_step_div.sv
// Counts frames between gain steps and pulses step when an interval ends.
// Assumes: active is low while the gain sits at its goal. The count is then
// cleared, so a new ramp always starts on a full interval.
module smute_step_div
    import smute_pkg::*;
#(
    parameter int NORM_FPS = 4,
    localparam int MAX_FPS = NORM_FPS * 4,
    localparam int CNT_W   = $clog2(MAX_FPS),
    localparam int FPS_W   = CNT_W + 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   active,
    input  speed_e speed,
    output logic   step
);
    logic [CNT_W-1:0] cnt_q;
    logic [FPS_W-1:0] fps;
    logic             last;

    // Frames per step for the selected rate mode
    always_comb begin
        unique case (speed)
            SPD_NORMAL: fps = FPS_W'(NORM_FPS);
            SPD_DOUBLE: fps = FPS_W'(NORM_FPS * 2);
            default:    fps = FPS_W'(MAX_FPS);
        endcase
    end

    assign last = ({1'b0, cnt_q} >= (fps - FPS_W'(1)));
    assign step = tick & active & last;

    // Frame counter, idle-cleared and wrapped at the end of each interval
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt_q <= '0;
        else if (tick)         cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/smute_gain_ramp.sv
// Holds the shared gain level and moves it one count per step toward its
// goal: zero while muted, the target level otherwise.
// Assumes: step is only raised while the level differs from the goal.
module smute_gain_ramp #(
    parameter int GAIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              mute_req,
    input  logic [GAIN_W-1:0] target,
    output logic [GAIN_W-1:0] gain,
    output logic              at_goal
);
    logic [GAIN_W-1:0] goal;
    logic [GAIN_W-1:0] gain_q;

    assign goal    = mute_req ? '0 : target;
    assign at_goal = (gain_q == goal);
    assign gain    = gain_q;

    // Load the target in power-down, otherwise step once toward the goal
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_q <= target;
        else if (step && !at_goal)
            gain_q <= (gain_q < goal) ? gain_q + GAIN_W'(1) : gain_q - GAIN_W'(1);
    end
endmodule

// File: rtl/smute_scaler.sv
// Multiplies one signed sample by gain/2^GAIN_W with truncation toward
// zero and registers the result on each frame tick.
// Assumes: the gain is unsigned and below 2^GAIN_W, so the result fits DATA_W.
module smute_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 8,
    localparam int PW    = DATA_W + GAIN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic signed [DATA_W-1:0] din,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] dout
);
    localparam logic signed [PW-1:0] BIAS = PW'((1 << GAIN_W) - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    // Signed product; negatives get a bias so the shift rounds toward zero
    always_comb begin
        prod   = PW'(din) * PW'($signed({1'b0, gain}));
        biased = prod[PW-1] ? prod + BIAS : prod;
    end

    // Capture the scaled sample once per frame
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (tick) dout <= DATA_W'(biased >>> GAIN_W);
    end
endmodule

// File: rtl/soft_mute_ramp.sv
// Soft-mute top: detects frame edges, times gain steps, ramps the shared
// gain and scales both channels.
// Assumes: all inputs are synchronous to clk; pwr_dn_n is synchronous
// active-low.
module soft_mute_ramp
    import smute_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int NORM_FPS = 4,
    localparam int NCH     = 2
) (
    input  logic                     clk,
    input  logic                     pwr_dn_n,
    input  logic                     word_clk,
    input  logic                     mute_req,
    input  logic        [GAIN_W-1:0] att_level,
    input  logic        [1:0]        speed_sel,
    input  logic signed [DATA_W-1:0] in_l,
    input  logic signed [DATA_W-1:0] in_r,
    output logic signed [DATA_W-1:0] out_l,
    output logic signed [DATA_W-1:0] out_r,
    output logic                     muted
);
    logic              frame_tick;
    logic              step_pulse;
    logic              at_goal;
    logic [GAIN_W-1:0] gain_lvl;
    logic signed [DATA_W-1:0] ch_in  [NCH];
    logic signed [DATA_W-1:0] ch_out [NCH];

    smute_edge_detect edge_i (
        .clk(clk), .rst_n(pwr_dn_n), .word_clk(word_clk), .tick(frame_tick)
    );

    smute_step_div #(.NORM_FPS(NORM_FPS)) div_i (
        .clk(clk), .rst_n(pwr_dn_n), .tick(frame_tick), .active(!at_goal),
        .speed(speed_e'(speed_sel)), .step(step_pulse)
    );

    smute_gain_ramp #(.GAIN_W(GAIN_W)) ramp_i (
        .clk(clk), .rst_n(pwr_dn_n), .step(step_pulse), .mute_req(mute_req),
        .target(att_level), .gain(gain_lvl), .at_goal(at_goal)
    );

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    // One scaler per channel, all sharing the gain level
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        smute_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) scl_i (
            .clk(clk), .rst_n(pwr_dn_n), .tick(frame_tick),
            .din(ch_in[c]), .gain(gain_lvl), .dout(ch_out[c])
        );
    end

    assign out_l = ch_out[0];
    assign out_r = ch_out[1];
    assign muted = mute_req && (gain_lvl == '0);
endmodule

// Temporal checks on the ramp and the output registers.
module smute_checker #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              muted,
    input logic [GAIN_W-1:0] gain,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r
);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(out_l) && $stable(out_r)));

    // R2
    gain_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && gain != $past(gain)) |->
            (({1'b0, gain} == {1'b0, $past(gain)} + 1'b1) ||
             ({1'b0, $past(gain)} == {1'b0, gain} + 1'b1)));

    // R4
    gain_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && gain != $past(gain)) |-> $past(tick));

    // R8
    muted_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        muted |=> (gain == '0));

    // R7
    silent_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gain == '0) |=> (out_l == '0 && out_r == '0));
endmodule

bind soft_mute_ramp smute_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) chk_i (
    .clk(clk), .rst_n(pwr_dn_n), .tick(frame_tick), .muted(muted),
    .gain(gain_lvl), .out_l(out_l), .out_r(out_r)
);

// File: tb/soft_mute_ramp_tb.sv
// Self-checking bench: arithmetic model of the gain counter and the scaling.
module soft_mute_ramp_tb_top;
    logic        clk = 1'b0;
    logic        pwr_dn_n = 1'b0;
    logic        word_clk = 1'b0;
    logic        mute_req = 1'b0;
    logic [7:0]  att_level = 8'd0;
    logic [1:0]  speed_sel = 2'b00;
    logic signed [23:0] in_l = '0;
    logic signed [23:0] in_r = '0;
    logic signed [23:0] out_l, out_r;
    logic        muted;

    int vectors = 0;
    int errors  = 0;
    int g = 0;
    int cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    soft_mute_ramp dut_i (
        .clk(clk), .pwr_dn_n(pwr_dn_n), .word_clk(word_clk), .mute_req(mute_req),
        .att_level(att_level), .speed_sel(speed_sel), .in_l(in_l), .in_r(in_r),
        .out_l(out_l), .out_r(out_r), .muted(muted)
    );

    function automatic int fps_of(int s);
        return (s == 0) ? 4 : (s == 1) ? 8 : 16;
    endfunction

    function automatic int scale(int x, int gg);
        longint p = longint'(x) * gg;
        return (p < 0) ? -int'((-p) / 256) : int'(p / 256);
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(int att);
        @(negedge clk);
        pwr_dn_n = 1'b0;
        att_level = 8'(att);
        repeat (3) @(negedge clk);
        pwr_dn_n = 1'b1;
        g = att;
        cnt = 0;
    endtask

    // One word-clock frame; the model advances and every output is compared
    task automatic frame(string req);
        int el, er, goal;
        el = scale(int'(in_l), g);
        er = scale(int'(in_r), g);
        goal = mute_req ? 0 : int'(att_level);
        if (g == goal) cnt = 0;
        else if (cnt >= fps_of(int'(speed_sel)) - 1) begin
            cnt = 0;
            g = (g < goal) ? g + 1 : g - 1;
        end else cnt++;
        @(negedge clk) word_clk = 1'b1;
        @(negedge clk);
        @(negedge clk) word_clk = 1'b0;
        @(negedge clk);
        check({req, " out_l"}, int'(out_l), el);
        check({req, " out_r"}, int'(out_r), er);
        check({req, " muted"}, int'(muted), int'(g == 0 && mute_req));
    endtask

    // Full fade down, then back up, with the duration counted in frames
    task automatic fade_pair(int att, int spd);
        int n;
        speed_sel = 2'(spd);
        mute_req = 1'b0;
        do_reset(att);
        in_l = 24'sd32768;
        in_r = -24'sd32768;
        mute_req = 1'b1;
        n = 0;
        while (g != 0 && n < 5000) begin frame("R2 fade down"); n++; end
        check("R6 down frames", n, att * fps_of(spd));
        check("R4 muted at end", int'(muted), 1);
        mute_req = 1'b0;
        n = 0;
        while (g != att && n < 5000) begin frame("R3 fade up"); n++; end
        check("R6 up frames", n, att * fps_of(spd));
    endtask

    initial begin
        int vals[8] = '{8388607, -8388608, -1, 1, -255, -257, 12345, -54321};

        // R1: outputs held in power-down; a high word clock at release is no edge
        pwr_dn_n = 1'b0;
        att_level = 8'd77;
        in_l = 24'sd1000;
        in_r = -24'sd1000;
        word_clk = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset out_l", int'(out_l), 0);
        check("R1 reset muted", int'(muted), 0);
        pwr_dn_n = 1'b1;
        g = 77;
        cnt = 0;
        repeat (5) @(negedge clk);
        check("R1 no edge out_l", int'(out_l), 0);
        check("R10 held out_r", int'(out_r), 0);
        word_clk = 1'b0;
        @(negedge clk);
        frame("R1 first frame");

        // R7: every gain level against extreme and rounding-sensitive inputs
        for (int lv = 0; lv < 256; lv++) begin
            do_reset(lv);
            foreach (vals[i]) begin
                in_l = 24'(vals[i]);
                in_r = 24'(-vals[i] - 1);
                frame("R7 scale");
            end
        end

        // R2 R3 R4 R6: fades at every rate mode
        fade_pair(255, 0);
        fade_pair(100, 1);
        fade_pair(100, 2);
        fade_pair(40, 3);

        // R5: reversals at offsets that are not multiples of the step length
        speed_sel = 2'b00;
        mute_req = 1'b0;
        do_reset(200);
        in_l = 24'sd32768;
        in_r = 24'sd32767;
        mute_req = 1'b1;
        for (int i = 0; i < 37; i++) frame("R5 down");
        mute_req = 1'b0;
        for (int i = 0; i < 13; i++) frame("R5 reverse up");
        mute_req = 1'b1;
        for (int i = 0; i < 6; i++) frame("R5 reverse down");
        mute_req = 1'b0;
        for (int i = 0; i < 60; i++) frame("R5 settle");
        check("R5 back at level", int'(out_l), 200 * 128);

        // R9: target changes while unmuted are followed step by step
        do_reset(100);
        att_level = 8'd90;
        frame("R9 first");
        frame("R9 no jump");
        check("R9 no jump level", int'(out_l), 100 * 128);
        for (int i = 0; i < 40; i++) frame("R9 down");
        check("R9 reached", int'(out_l), 90 * 128);
        att_level = 8'd95;
        for (int i = 0; i < 25; i++) frame("R9 up");
        check("R9 reached up", int'(out_l), 95 * 128);

        // R8: zero level without a mute request is not reported as muted
        do_reset(0);
        frame("R8 level zero");
        check("R8 no request", int'(muted), 0);
        mute_req = 1'b1;
        @(negedge clk);
        check("R8 request", int'(muted), 1);
        frame("R8 muted frame");
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule